// File: doc/BRIEF.md
# Slow Main Memory Emulator

This block models a slow, word-wide main memory that sits under a data cache. A requester raises `memAccess` together with the kind of access (`memWrite` or `memRead`), the word address, the write data and, for reads, `readBlock`. The memory answers with a fixed-latency handshake. `busy` covers the whole transfer. For reads, a one-cycle `startRead` strobe marks the point where the first word becomes valid on `rdData`.

A write commits one word. A read returns one word, or four consecutive words when `readBlock` is set. A four-word read starts at the requested word and continues with the three words after it, one per clock. The array holds plain data words, with no tags, and is addressed by whole words only. The depth is `2**ADDR_W` words. `ADDR_W = 16` gives the full 256 kB of 32-bit words, and the default is kept small.

After a transfer ends, the memory accepts no new request until the requester has dropped `memAccess` for at least one clock edge.

Top module: `slow_mem_emu`

## Requirements
- R1: During and right after reset, `busy` and `startRead` are low and `rdData` is zero.
- R2: From idle, `busy` goes high on the first rising edge at which `memAccess` is sampled high together with `memWrite` or `memRead`.
- R3: For a write, `busy` stays high for exactly 3 clock cycles. The word is stored at the edge where `busy` falls, and a later read returns it.
- R4: For a read, `startRead` is high for exactly one cycle, the third cycle of `busy`. It falls 3 cycles after `busy` rose, and at that same edge `rdData` takes the word at the requested address.
- R5: For a read with `readBlock` = 0, `busy` falls at the same edge as `startRead`.
- R6: For a read with `readBlock` = 1, the words at address+1, +2 and +3 appear on `rdData` at the next three rising edges. `busy` falls with the last of them. Addresses wrap modulo the depth.
- R7: Changes to address, data or access kind while `busy` is high have no effect on the current transfer. After `busy` falls, the memory stays idle while `memAccess` remains high.
- R8: A `memAccess` with neither `memWrite` nor `memRead` is ignored: `busy` stays low.
- R9: When `memWrite` and `memRead` are both high, the request is treated as a write: 3 busy cycles, no `startRead`, and the data is stored.
- R10: Outside read transfers `rdData` holds its last value, and a write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAccess | input | 1 | Request strobe, held until after `busy` falls |
| memWrite | input | 1 | Request is a write |
| memRead | input | 1 | Request is a read |
| readBlock | input | 1 | Read returns four consecutive words instead of one |
| wordAddr | input | ADDR_W | Word address of the access |
| wrData | input | DATA_W | Word to store on a write |
| busy | output | 1 | Transfer in progress |
| startRead | output | 1 | One-cycle strobe; first read word valid when it falls |
| rdData | output | DATA_W | Read word, updated once per beat |

## Verification
The assertions assume that the requester keeps `memAccess` high until at least one edge after `busy` falls, as a cache following the handshake would. They also assume that `busy` can only be started by a request carrying an access kind. Each bench task keeps `memAccess` asserted across the whole transfer and releases it only once `busy` is seen low. Where the bench deliberately breaks the rules, it does so only in ways the design is required to ignore: it changes address, data and kind in mid-transfer, holds the strobe past completion, or raises a request with no kind.

// File: rtl/slow_mem_pkg.sv
package slow_mem_pkg;

  // Number of words returned by a block read.
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_HOLD
  } memState_t;

  // Strobes from the controller to the datapath.
  typedef struct packed {
    logic              capture;   // latch address and write data
    logic              commitWr;  // store latched word
    logic              loadRd;    // load one read word onto the output
    logic [BEAT_W-1:0] beat;      // word offset within the block
  } memStrobes_t;

endpackage

// File: rtl/slow_mem_ctrl.sv
module slow_mem_ctrl
  import slow_mem_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        memAccess,
  input  logic        memWrite,
  input  logic        memRead,
  input  logic        readBlock,
  output logic        busy,
  output logic        startRead,
  output memStrobes_t strb
);

  localparam int CNT_W    = $clog2(LAT + BURST_LEN);
  localparam int FIRST_AT = LAT - 1;
  localparam int LAST_AT  = LAT - 1 + BURST_LEN - 1;

  memState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic             isBurst;
  logic             accept;
  logic             done;
  logic [CNT_W-1:0] beatRaw;

  assign accept  = (state == ST_IDLE) && memAccess && (memWrite || memRead);
  assign beatRaw = cnt - CNT_W'(FIRST_AT);

  always_comb begin
    strb          = '0;
    strb.capture  = accept;
    done          = 1'b0;
    if (state == ST_BUSY) begin
      if (isWrite) begin
        strb.commitWr = (cnt == CNT_W'(FIRST_AT));
        done          = (cnt == CNT_W'(FIRST_AT));
      end else begin
        strb.loadRd = (cnt >= CNT_W'(FIRST_AT));
        strb.beat   = beatRaw[BEAT_W-1:0];
        done        = isBurst ? (cnt == CNT_W'(LAST_AT))
                              : (cnt == CNT_W'(FIRST_AT));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      isBurst <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_BUSY;
            cnt     <= '0;
            isWrite <= memWrite;
            isBurst <= readBlock && !memWrite;
          end
        end
        ST_BUSY: begin
          if (done) state <= ST_HOLD;
          else      cnt   <= cnt + 1'b1;
        end
        ST_HOLD: begin
          if (!memAccess) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state == ST_BUSY);
  assign startRead = (state == ST_BUSY) && !isWrite && (cnt == CNT_W'(FIRST_AT));

endmodule

// File: rtl/slow_mem_dp.sv
module slow_mem_dp
  import slow_mem_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strb,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [ADDR_W-1:0] rdAddr;

  // Offset within the block wraps at the top of the array.
  assign rdAddr = addrQ + ADDR_W'(strb.beat);

  always_ff @(posedge clk) begin
    if (strb.commitWr) store[addrQ] <= dataQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      rdData <= '0;
    end else begin
      if (strb.capture) begin
        addrQ <= wordAddr;
        dataQ <= wrData;
      end
      if (strb.loadRd) rdData <= store[rdAddr];
    end
  end

endmodule

// File: rtl/slow_mem_emu.sv
module slow_mem_emu
  import slow_mem_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memAccess,
  input  logic              memWrite,
  input  logic              memRead,
  input  logic              readBlock,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              startRead,
  output logic [DATA_W-1:0] rdData
);

  memStrobes_t strb;

  slow_mem_ctrl #(.LAT(LAT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .memAccess (memAccess),
    .memWrite  (memWrite),
    .memRead   (memRead),
    .readBlock (readBlock),
    .busy      (busy),
    .startRead (startRead),
    .strb      (strb)
  );

  slow_mem_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wordAddr (wordAddr),
    .wrData   (wrData),
    .rdData   (rdData)
  );

endmodule

// File: rtl/slow_mem_chk.sv
module slow_mem_chk #(
  parameter int DATA_W = 32,
  parameter int LAT    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              memAccess,
  input logic              memWrite,
  input logic              memRead,
  input logic              busy,
  input logic              startRead,
  input logic [DATA_W-1:0] rdData
);

  localparam int BLK_LEN = LAT + slow_mem_pkg::BURST_LEN - 1;

  logic [7:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  always_ff @(posedge clk) begin
    if (rstN && !busy && busyLen != 8'd0) begin
      AST_BUSY_LEN: assert (busyLen == 8'(LAT) || busyLen == 8'(BLK_LEN)) // R6
        else $error("busy lasted %0d cycles", busyLen);
    end
  end

  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(memAccess && (memWrite || memRead))); // R2

  AST_SR_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    startRead |-> busy); // R4

  AST_SR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    startRead |=> !startRead); // R4

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(busy) && memAccess) |=> !busy); // R7

  AST_NO_KIND: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && memAccess && !memWrite && !memRead) |=> !busy); // R8

  AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(rdData)); // R10

endmodule

bind slow_mem_emu slow_mem_chk #(.DATA_W(DATA_W), .LAT(LAT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memAccess (memAccess),
  .memWrite  (memWrite),
  .memRead   (memRead),
  .busy      (busy),
  .startRead (startRead),
  .rdData    (rdData)
);

// File: tb/slow_mem_emu_tb.sv
module slow_mem_emu_tb;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              memAccess = 1'b0;
  logic              memWrite = 1'b0;
  logic              memRead = 1'b0;
  logic              readBlock = 1'b0;
  logic [ADDR_W-1:0] wordAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              busy;
  logic              startRead;
  logic [DATA_W-1:0] rdData;

  logic [DATA_W-1:0] model [DEPTH];
  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  slow_mem_emu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .memAccess(memAccess), .memWrite(memWrite),
    .memRead(memRead), .readBlock(readBlock), .wordAddr(wordAddr),
    .wrData(wrData), .busy(busy), .startRead(startRead), .rdData(rdData)
  );

  task automatic checkEq(string req, string what, logic [DATA_W-1:0] act,
                         logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic release_req();
    memAccess = 1'b0; memWrite = 1'b0; memRead = 1'b0; readBlock = 1'b0;
    @(negedge clk);
  endtask

  // Write with 3 busy cycles; 'both' also raises memRead (R9).
  task automatic doWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, bit both,
                         string req);
    @(negedge clk);
    memAccess = 1'b1; memWrite = 1'b1; memRead = both; wordAddr = a; wrData = d;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkEq(req, "write busy", busy, 1);
      checkEq(req, "write startRead", startRead, 0);
    end
    @(negedge clk);
    checkEq(req, "write busy end", busy, 0);
    model[a] = d;
    release_req();
  endtask

  task automatic doRead(logic [ADDR_W-1:0] a, bit blk, string req);
    @(negedge clk);
    memAccess = 1'b1; memRead = 1'b1; readBlock = blk; wordAddr = a;
    @(negedge clk);
    checkEq(req, "read busy c1", busy, 1);
    checkEq(req, "read startRead c1", startRead, 0);
    @(negedge clk);
    checkEq(req, "read startRead c2", startRead, 0);
    @(negedge clk);
    checkEq(req, "read busy c3", busy, 1);
    checkEq(req, "read startRead c3", startRead, 1);
    @(negedge clk);
    checkEq(req, "read startRead fall", startRead, 0);
    checkEq(req, "first word", rdData, model[a]);
    checkEq(req, "busy after first word", busy, DATA_W'(blk));
    if (blk) begin
      for (int k = 1; k < 4; k++) begin
        logic [ADDR_W-1:0] na;
        na = a + ADDR_W'(k);
        @(negedge clk);
        checkEq(req, "block word", rdData, model[na]);
        checkEq(req, "block busy", busy, (k == 3) ? 0 : 1);
      end
    end
    release_req();
  endtask

  task automatic test_reset();
    checkEq("R1", "busy in reset", busy, 0);
    checkEq("R1", "startRead in reset", startRead, 0);
    checkEq("R1", "rdData in reset", rdData, 0);
    @(negedge clk); rstN = 1'b1; @(negedge clk);
    checkEq("R1", "busy after reset", busy, 0);
  endtask

  task automatic test_rise();
    // R2: busy observed at the first negedge after the sampling edge.
    @(negedge clk);
    memAccess = 1'b1; memRead = 1'b1; wordAddr = 10'd4;
    checkEq("R2", "busy before edge", busy, 0);
    @(negedge clk);
    checkEq("R2", "busy after edge", busy, 1);
    repeat (3) @(negedge clk);
    release_req();
  endtask

  task automatic test_midchange();
    // R7: mid-transfer changes are ignored.
    @(negedge clk);
    memAccess = 1'b1; memWrite = 1'b1; wordAddr = 10'd20; wrData = 32'hAAAA_0001;
    @(negedge clk);
    wordAddr = 10'd21; wrData = 32'hBAD0_BAD0; memWrite = 1'b0; memRead = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R7", "busy end", busy, 0);
    model[20] = 32'hAAAA_0001;
    // hold strobe high past completion
    memWrite = 1'b1; wordAddr = 10'd20; wrData = 32'hDEAD_0002;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkEq("R7", "busy while strobe held", busy, 0);
    end
    release_req();
    doRead(10'd20, 1'b0, "R7");
    doRead(10'd21, 1'b0, "R7");
  endtask

  task automatic test_nokind();
    @(negedge clk);
    memAccess = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkEq("R8", "busy with no kind", busy, 0);
    end
    release_req();
  endtask

  task automatic test_hold_rd();
    logic [DATA_W-1:0] last;
    doRead(10'd7, 1'b0, "R10");
    last = rdData;
    doWrite(10'd8, 32'h0808_0808, 1'b0, "R10");
    checkEq("R10", "rdData after write", rdData, last);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = DATA_W'(i) * 32'h0001_0003 + 32'h55;
    repeat (2) @(negedge clk);
    test_reset();
    for (int i = 0; i < 8; i++)
      doWrite(ADDR_W'(i), 32'hC0DE_0000 + DATA_W'(i * 7), 1'b0, "R3");
    for (int i = 0; i < 4; i++)
      doWrite(ADDR_W'(DEPTH - 1 - i), 32'hF00D_0000 + DATA_W'(i), 1'b0, "R3");
    doWrite(10'd20, 32'h1111_2222, 1'b0, "R3");
    doWrite(10'd21, 32'h3333_4444, 1'b0, "R3");
    doWrite(10'd4, 32'h4444_4444, 1'b0, "R3");
    doWrite(10'd7, 32'h7777_7777, 1'b0, "R3");
    test_rise();
    doRead(10'd3, 1'b0, "R4");
    doRead(10'd5, 1'b0, "R5");
    doRead(10'd0, 1'b1, "R6");
    doRead(10'd2, 1'b1, "R6");
    doRead(ADDR_W'(DEPTH - 2), 1'b1, "R6");
    test_midchange();
    test_nokind();
    doWrite(10'd30, 32'h9999_0030, 1'b1, "R9");
    doRead(10'd30, 1'b0, "R9");
    test_hold_rd();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule